// File: doc/BRIEF.md
# Status Flags and Branch Condition Evaluator

This block sits beside an 8-bit ALU. When an operation that sets the condition flags finishes, the update strobe is raised. The block then captures four flags from the result byte and from the carries into and out of the most significant bit: carry, sign, zero and overflow. Compare and test operations rely on this. They leave every register untouched and only change these flags.

A 4-bit condition code picks one branch test. The block reports, combinationally, whether that test passes against the latched flags. The tests cover three groups: the single-flag tests, the unsigned magnitude comparisons and the signed magnitude comparisons. The comparisons assume the flags came from a subtract A-B computed as A + ~B + 1. Updating the program counter is left to the surrounding control logic.

Top module: `flag_branch_unit`

## Requirements
- R1: While rst_ni is low, flags_o reads 4'b0000. The field order is flags_o[3]=overflow, [2]=zero, [1]=sign, [0]=carry.
- R2: On a rising clk_i edge with upd_i high, the carry flag takes the value of msb_cout_i.
- R3: On a rising clk_i edge with upd_i high, the sign flag takes the value of res_i[7].
- R4: On a rising clk_i edge with upd_i high, the zero flag becomes 1 exactly when res_i is 8'h00.
- R5: On a rising clk_i edge with upd_i high, the overflow flag becomes msb_cin_i XOR msb_cout_i.
- R6: On a rising clk_i edge with upd_i low, all four flags keep their values, whatever res_i and the carries do.
- R7: take_o is combinational from cond_i and the latched flags. cond_i[0]=1 inverts the test that cond_i[3:1] selects. The single-flag codes are: 0 zero set, 1 zero clear, 2 carry set, 3 carry clear, 4 sign set (minus), 5 sign clear (plus), 6 overflow set, 7 overflow clear.
- R8: After A-B, the unsigned codes are: 8 higher (C & ~Z), 9 lower-or-same, 14 higher-or-same (C), 15 lower (~C). Equal and not-equal use codes 0 and 1.
- R9: After A-B, the signed codes are: 10 greater-or-equal (~(S^V)), 11 less (S^V), 12 greater (~(S^V) & ~Z), 13 less-or-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 8 | ALU result byte |
| msb_cin_i | input | 1 | Carry into bit 7 |
| msb_cout_i | input | 1 | Carry out of bit 7 |
| upd_i | input | 1 | Flag capture strobe |
| cond_i | input | 4 | Branch condition code |
| flags_o | output | 4 | Latched flags {V,Z,S,C} |
| take_o | output | 1 | Selected condition passes |

## Verification
Each table vector subtracts one operand pair, and the expected branch outcomes come from plain integer comparisons of the two operands. The pairs are chosen so the outcomes pull apart:
- Equal operands separate the strict tests from the or-equal tests.
- Operands whose unsigned and signed orderings disagree (such as 8'h80 against 8'h01) separate the unsigned group from the signed group.
- Pairs that cross the signed range (8'h7F minus 8'hFF, 8'h80 minus 8'h7F) set overflow, so a signed test that ignores V gives the wrong answer.

Directed raw inputs then check the following:
- Overflow comes from the two carries, independent of the result byte.
- Flags hold while the strobe is low.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned COND_W = 4;

  typedef struct packed {
    logic v;
    logic z;
    logic s;
    logic c;
  } flags_t;

  typedef enum logic [2:0] {
    B_ZERO = 3'd0,
    B_CARRY = 3'd1,
    B_SIGN = 3'd2,
    B_OVF = 3'd3,
    B_UHI = 3'd4,
    B_SGE = 3'd5,
    B_SGT = 3'd6,
    B_UHS = 3'd7
  } base_cond_e;
endpackage

// File: rtl/flag_gen.sv
module flag_gen
  import flag_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] res_i,
  input  logic          msb_cin_i,
  input  logic          msb_cout_i,
  output flags_t        flags_o
);
  always_comb begin
    flags_o.c = msb_cout_i;
    flags_o.s = res_i[DW-1];
    flags_o.z = ~|res_i;
    flags_o.v = msb_cin_i ^ msb_cout_i;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_pkg::*;
#(
  parameter int unsigned CW = COND_W
) (
  input  flags_t        flags_i,
  input  logic [CW-1:0] cond_i,
  output logic          take_o
);
  localparam int unsigned NBASE = 2 ** (CW - 1);

  logic [NBASE-1:0] base;
  logic             lt;

  // signed less-than after A-B
  assign lt = flags_i.s ^ flags_i.v;

  always_comb begin
    base = '0;
    base[B_ZERO]  = flags_i.z;
    base[B_CARRY] = flags_i.c;
    base[B_SIGN]  = flags_i.s;
    base[B_OVF]   = flags_i.v;
    base[B_UHI]   = flags_i.c & ~flags_i.z;
    base[B_SGE]   = ~lt;
    base[B_SGT]   = ~lt & ~flags_i.z;
    base[B_UHS]   = flags_i.c;
  end

  // bit 0 of the code inverts the selected base test
  assign take_o = base[cond_i[CW-1:1]] ^ cond_i[0];
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import flag_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = COND_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] res_i,
  input  logic          msb_cin_i,
  input  logic          msb_cout_i,
  input  logic          upd_i,
  input  logic [CW-1:0] cond_i,
  output logic [3:0]    flags_o,
  output logic          take_o
);
  flags_t next_flags;
  flags_t cur_flags;

  flag_gen #(.DW(DW)) u_gen (
    .res_i     (res_i),
    .msb_cin_i (msb_cin_i),
    .msb_cout_i(msb_cout_i),
    .flags_o   (next_flags)
  );

  flag_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd_i),
    .d_i   (next_flags),
    .q_o   (cur_flags)
  );

  cond_eval #(.CW(CW)) u_eval (
    .flags_i(cur_flags),
    .cond_i (cond_i),
    .take_o (take_o)
  );

  assign flags_o = cur_flags;
endmodule

// File: rtl/flag_branch_unit_chk.sv
module flag_branch_unit_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] res_i,
  input logic          msb_cin_i,
  input logic          msb_cout_i,
  input logic          upd_i,
  input logic [CW-1:0] cond_i,
  input logic [3:0]    flags_o,
  input logic          take_o
);
  a_r2_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o[0] == $past(msb_cout_i));
  a_r3_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o[1] == $past(res_i[DW-1]));
  a_r4_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o[2] == ($past(res_i) == '0));
  a_r5_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o[3] == ($past(msb_cin_i) ^ $past(msb_cout_i)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));
  a_r7_zero_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd0) |-> take_o == flags_o[2]);
  a_r8_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd8) |-> take_o == (flags_o[0] & ~flags_o[2]));
  a_r9_less: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd11) |-> take_o == (flags_o[1] ^ flags_o[3]));
endmodule

bind flag_branch_unit flag_branch_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .res_i     (res_i),
  .msb_cin_i (msb_cin_i),
  .msb_cout_i(msb_cout_i),
  .upd_i     (upd_i),
  .cond_i    (cond_i),
  .flags_o   (flags_o),
  .take_o    (take_o)
);

// File: tb/tb_flag_branch_unit.sv
`timescale 1ns/1ps
module tb_flag_branch_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] res_i = '0;
  logic       msb_cin_i = 1'b0;
  logic       msb_cout_i = 1'b0;
  logic       upd_i = 1'b0;
  logic [3:0] cond_i = '0;
  logic [3:0] flags_o;
  logic       take_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  flag_branch_unit dut (.*);

  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    16'h0503, 16'h0305, 16'h0707, 16'h8001, 16'h7FFF,
    16'h0000, 16'hFF01, 16'h807F, 16'h01FF, 16'hFE7F
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [7:0] a, input logic [7:0] b, input int c);
    int sa, sb, sd;
    bit ov;
    logic [7:0] d;
    sa = int'($signed(a));
    sb = int'($signed(b));
    sd = sa - sb;
    ov = (sd > 127) || (sd < -128);
    d = a - b;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return a >= b;
      3: return a < b;
      4: return d[7];
      5: return !d[7];
      6: return ov;
      7: return !ov;
      8: return a > b;
      9: return a <= b;
      10: return sa >= sb;
      11: return sa < sb;
      12: return sa > sb;
      13: return sa <= sb;
      14: return a >= b;
      default: return a < b;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    if (c < 8) return "R7";
    if (c == 8 || c == 9 || c >= 14) return "R8";
    return "R9";
  endfunction

  task automatic load_sub(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] full;
    logic [7:0] low;
    full = {1'b0, a} + {1'b0, ~b} + 9'd1;
    low = {1'b0, a[6:0]} + {1'b0, ~b[6:0]} + 8'd1;
    res_i = full[7:0];
    msb_cout_i = full[8];
    msb_cin_i = low[7];
    upd_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    upd_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1 reset flags", {4'h0, flags_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags after release", {4'h0, flags_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] a, b, d;
      logic [8:0] full;
      logic [7:0] low;
      a = VEC[i][15:8];
      b = VEC[i][7:0];
      d = a - b;
      full = {1'b0, a} + {1'b0, ~b} + 9'd1;
      low = {1'b0, a[6:0]} + {1'b0, ~b[6:0]} + 8'd1;
      load_sub(a, b);
      chk("R2 carry", {7'd0, flags_o[0]}, {7'd0, full[8]});
      chk("R3 sign", {7'd0, flags_o[1]}, {7'd0, d[7]});
      chk("R4 zero", {7'd0, flags_o[2]}, {7'd0, d == 8'h00});
      chk("R5 overflow", {7'd0, flags_o[3]}, {7'd0, low[7] ^ full[8]});
      for (int c = 0; c < 16; c++) begin
        cond_i = 4'(c);
        #1;
        chk($sformatf("%s cond=%0d a=%h b=%h", tag_of(c), c, a, b),
            {7'd0, take_o}, {7'd0, exp_take(a, b, c)});
      end
    end

    // R5: overflow from carries only, zero result with carry-in only
    res_i = 8'h00; msb_cin_i = 1'b1; msb_cout_i = 1'b0; upd_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); upd_i = 1'b0;
    chk("R5 raw cin only", {4'h0, flags_o}, 8'h0C);
    res_i = 8'h80; msb_cin_i = 1'b1; msb_cout_i = 1'b1; upd_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); upd_i = 1'b0;
    chk("R5 raw both carries", {4'h0, flags_o}, 8'h03);

    // R6: hold while strobe low
    res_i = 8'h00; msb_cin_i = 1'b0; msb_cout_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R6 hold flags", {4'h0, flags_o}, 8'h03);
    cond_i = 4'd0; #1;
    chk("R6 hold zero test", {7'd0, take_o}, 8'h00);

    // R7: take follows cond combinationally, no clock
    cond_i = 4'd4; #1;
    chk("R7 minus test", {7'd0, take_o}, 8'h01);
    cond_i = 4'd5; #1;
    chk("R7 plus test", {7'd0, take_o}, 8'h00);

    // R1: asynchronous reset clears latched flags
    #3 rst_ni = 1'b0; #2;
    chk("R1 async clear", {4'h0, flags_o}, 8'h00);
    cond_i = 4'd15; #1;
    chk("R8 lower after reset", {7'd0, take_o}, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule